// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Controller

This block sits on the processor side of an external memory bus whose low address byte and data byte travel over the same set of lines. An internal requester hands it a 20-bit byte address with a request strobe. The block runs one external read cycle for that request. First it drives the full address with an address-latch strobe high, so that outside logic can hold the low byte. It then releases the shared lines and raises the read strobe. It stretches the cycle with wait states for as long as the memory holds READY low. When READY is seen high, it captures the byte.

The shared lines are modelled as a tri-state pair: a drive-enable with a value out, plus a separate value in. The upper twelve address bits have their own dedicated outputs. The captured byte is returned with a one-cycle done pulse and stays on the response port until the next read completes. The block handles one read at a time and takes a new request only while idle.

Top module: `mux_read_ctrl`

## Requirements
- R1: A request is taken only in the idle state. In the cycle after the accepting clock edge, the block raises `bus_ale` and `bus_ad_oe` and drives `req_addr[7:0]` on `bus_ad_out`. A request seen in any other state has no effect on the cycle in progress.
- R2: The next cycle is the strobe phase: `bus_ale` and `bus_ad_oe` are low and `bus_rd` is high. Whenever `bus_rd` is high, the shared lines are not driven.
- R3: From the address phase until the done cycle, `bus_addr_hi` carries bits 19..8 of the accepted address, without change.
- R4: After the strobe phase, `bus_ready` is sampled at the end of every access cycle. While it is 0, a further access cycle follows, with `bus_rd` high and the address held. A read with N wait states therefore keeps `bus_rd` high for N+2 cycles.
- R5: At least one access cycle always occurs, even when `bus_ready` is already high during the address and strobe phases.
- R6: The byte on `bus_ad_in` at the clock edge where `bus_ready` is sampled 1 is the byte returned on `rsp_data`. Values present on `bus_ad_in` during wait states are not returned.
- R7: `rsp_done` is high for exactly one cycle: the cycle after the capture edge, in which `bus_rd` is low. `rsp_data` changes only as `rsp_done` rises.
- R8: While `rst_n` is low, the block is idle and `bus_ale`, `bus_ad_oe`, `bus_rd`, `rsp_done`, `rsp_data`, `bus_addr_hi` and `bus_ad_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request, taken when idle |
| req_addr | input | 20 | Byte address of the request |
| rsp_done | output | 1 | One-cycle pulse when read data is valid |
| rsp_data | output | 8 | Last captured byte |
| bus_addr_hi | output | 12 | Dedicated upper address bits 19..8 |
| bus_ad_out | output | 8 | Value driven on the shared low-byte lines |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_in | input | 8 | Value read back from the shared lines |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Memory read strobe |
| bus_ready | input | 1 | Memory ready, low inserts wait states |

## Verification
The hardest case to reach from the ports is a wait state in which the shared lines carry a byte that must not be captured, while a competing request is pending. The bench's memory model puts junk on `bus_ad_in` on every cycle in which it holds READY low. It puts the true byte there only when READY rises, and it keeps `req` high with a different address for the whole busy period. Reads with zero, one, three and seven waits are run. READY is pulled high early during the address and strobe phases to show that the minimum access cycle is still taken.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRB,
        ST_ACC,
        ST_END
    } rd_state_e;
endpackage

// File: rtl/mrc_seq.sv
module mrc_seq
    import mrc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ready,
    output logic [ADDR_W-1:0] addr,
    output logic              ale,
    output logic              ad_oe,
    output logic              rd,
    output logic              cap_en
);
    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req) begin
                    nxt_d.st   = ST_ADDR;
                    nxt_d.addr = req_addr;
                end
            end
            ST_ADDR: nxt_d.st = ST_STRB;
            ST_STRB: nxt_d.st = ST_ACC;
            ST_ACC:  if (ready) nxt_d.st = ST_END;
            ST_END:  nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, addr: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr   = cur_q.addr;
    assign ale    = (cur_q.st == ST_ADDR);
    assign ad_oe  = (cur_q.st == ST_ADDR);
    assign rd     = (cur_q.st == ST_STRB) || (cur_q.st == ST_ACC);
    assign cap_en = (cur_q.st == ST_ACC) && ready;
endmodule

// File: rtl/mrc_capture.sv
module mrc_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = cap_en;
        if (cap_en) begin
            cap_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign done = cap_q.done;
    assign dout = cap_q.data;
endmodule

// File: rtl/mux_read_ctrl.sv
module mux_read_ctrl #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_data,
    output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
    output logic [DATA_W-1:0]        bus_ad_out,
    output logic                     bus_ad_oe,
    input  logic [DATA_W-1:0]        bus_ad_in,
    output logic                     bus_ale,
    output logic                     bus_rd,
    input  logic                     bus_ready
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_w;
    logic              cap_w;

    mrc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_addr (req_addr),
        .ready    (bus_ready),
        .addr     (addr_w),
        .ale      (bus_ale),
        .ad_oe    (bus_ad_oe),
        .rd       (bus_rd),
        .cap_en   (cap_w)
    );

    mrc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_w),
        .din    (bus_ad_in),
        .done   (rsp_done),
        .dout   (rsp_data)
    );

    assign bus_addr_hi = addr_w[ADDR_W-1 -: HI_W];
    assign bus_ad_out  = addr_w[DATA_W-1:0];
endmodule

// File: rtl/mux_read_ctrl_chk.sv
module mux_read_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rsp_done,
    input logic [DATA_W-1:0]        rsp_data,
    input logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
    input logic                     bus_ad_oe,
    input logic                     bus_ale,
    input logic                     bus_rd,
    input logic                     bus_ready
);
    // R1: the read strobe only follows an address-latch phase
    a_r1_ale_before_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> $past(bus_ale));

    // R2: shared lines released and latch strobe low while reading
    a_r2_release_lines: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (!bus_ad_oe && !bus_ale));

    // R3: upper address stays put through the read phases and done
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || rsp_done) |-> $stable(bus_addr_hi));

    // R4: an access cycle with READY low is followed by another one
    a_r4_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd) && !bus_ready) |=> (bus_rd && !bus_ale));

    // R5: done needs a strobe cycle and at least one access cycle before it
    a_r5_min_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> ($past(bus_rd) && $past(bus_rd, 2)));

    // R7: single-cycle done, data moves only with done
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rsp_done) |-> $stable(rsp_data));
endmodule

bind mux_read_ctrl mux_read_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_done    (rsp_done),
    .rsp_data    (rsp_data),
    .bus_addr_hi (bus_addr_hi),
    .bus_ad_oe   (bus_ad_oe),
    .bus_ale     (bus_ale),
    .bus_rd      (bus_rd),
    .bus_ready   (bus_ready)
);

// File: tb/mux_read_ctrl_bench.sv
module mux_read_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] req_addr = '0;
    logic        rsp_done;
    logic [7:0]  rsp_data;
    logic [11:0] bus_addr_hi;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_ale;
    logic        bus_rd;
    logic        bus_ready = 1'b0;

    mux_read_ctrl u_mux_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .bus_addr_hi(bus_addr_hi),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_ready(bus_ready)
    );

    always #10 clk = ~clk;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;

    // reference model: phase 0 idle, 1 address, 2 strobe, 3 access, 4 done
    int          ph = 0;
    int          acc = 0;
    logic [19:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    // bench-side bus environment
    int          cur_w = 0;
    logic [19:0] ext_latch = '0;
    logic [7:0]  lfsr = 8'hA7;
    int          rd_cycles = 0;

    function automatic logic [7:0] memf(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; acc = 0; m_addr = '0; m_data = '0;
        end else begin
            case (ph)
                0: if (req) begin m_addr = req_addr; ph = 1; end
                1: ph = 2;
                2: begin ph = 3; acc = 0; end
                3: if (bus_ready) begin m_data = bus_ad_in; ph = 4; end else acc++;
                default: ph = 0;
            endcase
        end
    end

    task automatic compare();
        chk(bus_ale == (ph == 1), "R1 ale", bus_ale, ph == 1);
        chk(bus_ad_oe == (ph == 1), "R1 oe", bus_ad_oe, ph == 1);
        if (ph == 1) chk(bus_ad_out == m_addr[7:0], "R1 low byte", bus_ad_out, m_addr[7:0]);
        chk(bus_rd == (ph == 2 || ph == 3), "R2/R4 rd", bus_rd, ph == 2 || ph == 3);
        if (ph != 0) chk(bus_addr_hi == m_addr[19:8], "R3 addr_hi", bus_addr_hi, m_addr[19:8]);
        chk(rsp_done == (ph == 4), "R7 done", rsp_done, ph == 4);
        chk(rsp_data == m_data, "R6/R7 data", rsp_data, m_data);
        if (ph == 4) chk(rsp_data == memf(ext_latch), "R6 mem byte", rsp_data, memf(ext_latch));
    endtask

    task automatic drive_bus();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (bus_ale) ext_latch = {bus_addr_hi, bus_ad_out};
        if (bus_rd) rd_cycles++;
        if (ph == 3) bus_ready = (acc >= cur_w);
        else bus_ready = lfsr[0];   // R5: early READY must not shorten the cycle
        bus_ad_in = (ph == 3 && bus_ready) ? memf(ext_latch) : ~memf(ext_latch) ^ lfsr;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        drive_bus();
    endtask

    task automatic do_rd(input logic [19:0] a, input int w, input bit hold);
        cur_w = w;
        rd_cycles = 0;
        req = 1'b1;
        req_addr = a;
        step();
        if (hold) req_addr = a ^ 20'h5A5A5;  // R1: mid-cycle request ignored
        else req = 1'b0;
        while (ph != 4) step();
        req = 1'b0;
        step();
        chk(rd_cycles == w + 2, "R4/R5 rd length", rd_cycles, w + 2);
        chk(rsp_data == memf(a), "R6 final byte", rsp_data, memf(a));
        step();
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(!bus_ale && !bus_ad_oe && !bus_rd && !rsp_done, "R8 strobes", {bus_ale, bus_ad_oe, bus_rd, rsp_done}, 0);
            chk(rsp_data == 0 && bus_addr_hi == 0 && bus_ad_out == 0, "R8 values", {rsp_data, bus_addr_hi, bus_ad_out}, 0);
        end
        rst_n = 1'b1;
        step();
        do_rd(20'h12345, 0, 1'b0);
        do_rd(20'hFFFFF, 1, 1'b0);
        do_rd(20'h00000, 3, 1'b1);
        do_rd(20'hA5C3E, 7, 1'b1);
        do_rd(20'h80001, 0, 1'b1);
        do_rd(20'h7F0FF, 2, 1'b0);
        repeat (3) step();
        chk(rsp_data == memf(20'h7F0FF), "R7 data held", rsp_data, memf(20'h7F0FF));
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule